// File: doc/BRIEF.md
# Dual FM Bank Port Router

This block sits between a narrow I/O window and the register files of FM tone generators. The window has sixteen byte-wide port offsets. Even offsets latch a register address and odd offsets carry the value written to that register. The router turns each data write into a registered write on one or two bank lanes. Depending on the selected personality, it drives a single 8-bit register space, a single 9-bit extended register space, or two independent 8-bit banks.

In the two-bank personality, one write can go to either bank or to both at once. The router also cleans the data for that personality. Writes to the mode-switch register are dropped, waveform values are clipped, and channel-output bits are forced so that bank 0 plays on one side and bank 1 on the other. The extended personality with control adds a small hidden register set behind magic address values. It holds a left and a right volume byte and a few fixed identification reads.

Reads return the status byte of the tone generators, which is supplied from outside and passed through, or the control registers. All other read offsets return the idle value.

Top module: `fm_port_router`

## Requirements
- R1: `mode_sel` encodes 0 = single, 1 = dual, 2 = extended, 3 = extended with control. A write with `port_off[0]`=0 latches an address and a write with `port_off[0]`=1 is a data write. In single mode a data write appears on lane 0 one clock later, with `bank0_addr` = {0, last latched byte} and `bank0_data` unmodified; lane 1 stays idle.
- R2: In extended modes an address write latches {`port_off[1]`, byte} as the 9-bit address, and data writes go to lane 0 unmodified, whatever the register number.
- R3: In dual mode with `port_off[3]`=0, `port_off[1]` selects the bank for both address and data writes. Bank 0 writes appear on lane 0 with address {0, reg}, and bank 1 writes appear on lane 1 with address 0x100 + reg.
- R4: In dual mode with `port_off[3]`=1, an address write sets the addresses of both banks, and a data write drives both lanes in the same cycle.
- R5: In dual mode a data write aimed at register 0x05 produces no lane write.
- R6: In dual mode a value written to register 0xE0 or above keeps only its low 2 bits. Register 0xDF is passed unchanged.
- R7: In dual mode a value written to registers 0xC0 to 0xC8 keeps its low 4 bits and gains 0x50 on bank 0 or 0xA0 on bank 1. Register 0xC9 is unchanged.
- R8: In mode 3, an address write of 0xFF at offset 2 unlocks the control set and 0xFE locks it. Neither value changes the bank address. While the set is unlocked, other address writes at offset 2 set the control index instead of the bank address. While it is locked, offsets 2 and 3 act as in extended mode.
- R9: While the set is unlocked, a data write at offset 3 goes to no lane. With index 0x09 it sets `vol_left`, with index 0x0A it sets `vol_right`, and with any other index it changes nothing.
- R10: While the set is unlocked, a read at offset 2 returns 0x00. A read at offset 3 returns 0x70 for index 0x00, 0x71 for index 0x15, the matching volume for index 0x09 or 0x0A, and 0xFF for any other index.
- R11: Status reads use `port_off[1:0]`=0. Single mode returns `stat_a` OR 0x06. Extended modes return `stat_a` unchanged. Dual mode returns, at any even offset, the status of the bank selected by `port_off[1]` OR 0x06. All other reads return 0xFF.
- R12: After reset both lanes are idle, both volumes are 0xFF, the control set is locked, and all latched addresses and the control index are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Personality select (see R1) |
| port_off | input | 4 | Port offset within the I/O window |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write byte |
| stat_a | input | 8 | Status byte of bank 0 tone generator |
| stat_b | input | 8 | Status byte of bank 1 tone generator |
| rd_data | output | 8 | Read byte for the current `port_off` |
| bank0_we | output | 1 | Lane 0 register write strobe |
| bank0_addr | output | 9 | Lane 0 register address |
| bank0_data | output | 8 | Lane 0 register value |
| bank1_we | output | 1 | Lane 1 register write strobe |
| bank1_addr | output | 9 | Lane 1 register address (0x100 + reg) |
| bank1_data | output | 8 | Lane 1 register value |
| vol_left | output | 8 | Left volume control byte |
| vol_right | output | 8 | Right volume control byte |

## Verification
The assertions assume that `mode_sel` changes only between accesses. They also assume that `wr_en` is a single-cycle strobe with `port_off` and `wr_data` steady while it is high. The lane properties relate each output strobe to the previous cycle's inputs, so they hold only when each access is a clean single cycle. The directed tasks respect this by changing `mode_sel` only while `wr_en` is low, and by raising `wr_en` for exactly one cycle per access on the falling clock edge.

// File: rtl/fm_router_pkg.sv
// Shared personality encoding and fixed codes of the FM port router.
// Assumes byte-wide port data; the codes are widened by their users.
package fm_router_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'd0,
        MODE_DUAL     = 2'd1,
        MODE_EXT      = 2'd2,
        MODE_EXT_CTRL = 2'd3
    } route_mode_e;

    localparam logic [7:0] KEY_UNLOCK   = 8'hFF;
    localparam logic [7:0] KEY_LOCK     = 8'hFE;
    localparam logic [7:0] IDX_BOARD    = 8'h00;
    localparam logic [7:0] IDX_VOL_L    = 8'h09;
    localparam logic [7:0] IDX_VOL_R    = 8'h0A;
    localparam logic [7:0] IDX_RELOC    = 8'h15;
    localparam logic [7:0] RD_BOARD     = 8'h70;
    localparam logic [7:0] RD_RELOC     = 8'h71;
    localparam logic [7:0] REG_MODESW   = 8'h05;
    localparam logic [7:0] REG_WAVE_LO  = 8'hE0;
    localparam logic [7:0] REG_PAN_LO   = 8'hC0;
    localparam logic [7:0] REG_PAN_HI   = 8'hC8;
    localparam logic [7:0] STAT_OR_BITS = 8'h06;

endpackage

// File: rtl/fm_addr_latch.sv
// Register-address latches: one extended-width latch for the single and
// extended personalities, plus one per bank for the dual personality.
// Assumes ld is already cleared for address writes taken by the control set.
module fm_addr_latch
    import fm_router_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 4,
    parameter int NBANK  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  route_mode_e       mode,
    input  logic [OFF_W-1:0]  port_off,
    input  logic              ld,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W:0]   main_addr,
    output logic [DATA_W-1:0] bank_addr [NBANK]
);

    // Main latch: bit above the byte comes from offset bit 1 in extended modes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            main_addr <= '0;
        else if (ld && mode != MODE_DUAL)
            main_addr <= {(mode != MODE_SINGLE) && port_off[1], din};
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Per-bank latch: loaded when selected by offset bit 1 or broadcast.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_addr[b] <= '0;
            else if (ld && mode == MODE_DUAL &&
                     (port_off[3] || (port_off[1] == 1'(b))))
                bank_addr[b] <= din;
        end
    end

endmodule

// File: rtl/fm_ctrl_regs.sv
// Hidden control register set: lock state, index, two volume bytes and
// the read-back decode. Strobes arrive already qualified by mode and offset.
module fm_ctrl_regs
    import fm_router_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_stb,
    input  logic              data_stb,
    input  logic [DATA_W-1:0] din,
    output logic              unlocked,
    output logic              addr_take,
    output logic              data_take,
    output logic [DATA_W-1:0] vol_l,
    output logic [DATA_W-1:0] vol_r,
    output logic [DATA_W-1:0] rd_val
);

    logic [DATA_W-1:0] idx;

    // Magic values and unlocked index writes are consumed here.
    assign addr_take = addr_stb &&
                       (din == DATA_W'(KEY_UNLOCK) || din == DATA_W'(KEY_LOCK) || unlocked);
    assign data_take = data_stb && unlocked;

    // Lock state and index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            idx      <= '0;
        end else if (addr_stb) begin
            if (din == DATA_W'(KEY_UNLOCK))
                unlocked <= 1'b1;
            else if (din == DATA_W'(KEY_LOCK))
                unlocked <= 1'b0;
            else if (unlocked)
                idx <= din;
        end
    end

    // Volume bytes written through the data port while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_l <= '1;
            vol_r <= '1;
        end else if (data_take) begin
            if (idx == DATA_W'(IDX_VOL_L))
                vol_l <= din;
            else if (idx == DATA_W'(IDX_VOL_R))
                vol_r <= din;
        end
    end

    // Read-back decode of the current index.
    always_comb begin
        if (idx == DATA_W'(IDX_BOARD))
            rd_val = DATA_W'(RD_BOARD);
        else if (idx == DATA_W'(IDX_VOL_L))
            rd_val = vol_l;
        else if (idx == DATA_W'(IDX_VOL_R))
            rd_val = vol_r;
        else if (idx == DATA_W'(IDX_RELOC))
            rd_val = DATA_W'(RD_RELOC);
        else
            rd_val = '1;
    end

endmodule

// File: rtl/fm_bank_scrub.sv
// Dual-personality value cleaner for one bank: drops mode-switch writes,
// clips waveform values and forces the side bits on channel-output registers.
module fm_bank_scrub
    import fm_router_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BANK_ID = 0
) (
    input  logic [DATA_W-1:0] reg_idx,
    input  logic [DATA_W-1:0] val_in,
    output logic              keep,
    output logic [DATA_W-1:0] val_out
);

    localparam logic [DATA_W-1:0] SIDE_BITS = (BANK_ID == 0) ? DATA_W'(8'h50) : DATA_W'(8'hA0);
    localparam logic [DATA_W-1:0] LOW2      = DATA_W'(8'h03);
    localparam logic [DATA_W-1:0] LOW4      = DATA_W'(8'h0F);

    assign keep = (reg_idx != DATA_W'(REG_MODESW));

    // Value rewrite by register range.
    always_comb begin
        if (reg_idx >= DATA_W'(REG_WAVE_LO))
            val_out = val_in & LOW2;
        else if (reg_idx >= DATA_W'(REG_PAN_LO) && reg_idx <= DATA_W'(REG_PAN_HI))
            val_out = (val_in & LOW4) | SIDE_BITS;
        else
            val_out = val_in;
    end

endmodule

// File: rtl/fm_port_router.sv
// Top of the FM port router: decodes the port window, routes data writes
// to two registered bank lanes and muxes read data.
// Assumes single-cycle write strobes and mode changes only between accesses.
module fm_port_router
    import fm_router_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [OFF_W-1:0]  port_off,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] stat_a,
    input  logic [DATA_W-1:0] stat_b,
    output logic [DATA_W-1:0] rd_data,
    output logic              bank0_we,
    output logic [DATA_W:0]   bank0_addr,
    output logic [DATA_W-1:0] bank0_data,
    output logic              bank1_we,
    output logic [DATA_W:0]   bank1_addr,
    output logic [DATA_W-1:0] bank1_data,
    output logic [DATA_W-1:0] vol_left,
    output logic [DATA_W-1:0] vol_right
);

    localparam int NBANK = 2;
    localparam int REG_W = DATA_W + 1;
    localparam logic [OFF_W-1:0] OFF_CADDR = OFF_W'(2);
    localparam logic [OFF_W-1:0] OFF_CDATA = OFF_W'(3);

    route_mode_e       mode;
    logic              wr_addr, wr_val, ctrl_mode;
    logic              unlocked, addr_take, data_take;
    logic [DATA_W-1:0] ctrl_rd;
    logic [DATA_W:0]   main_addr;
    logic [DATA_W-1:0] bank_addr [NBANK];
    logic [NBANK-1:0]  keep, hit;
    logic [DATA_W-1:0] clean [NBANK];

    assign mode      = route_mode_e'(mode_sel);
    assign wr_addr   = wr_en && !port_off[0];
    assign wr_val    = wr_en &&  port_off[0];
    assign ctrl_mode = (mode == MODE_EXT_CTRL);

    fm_ctrl_regs #(.DATA_W(DATA_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_stb  (wr_addr && ctrl_mode && port_off == OFF_CADDR),
        .data_stb  (wr_val  && ctrl_mode && port_off == OFF_CDATA),
        .din       (wr_data),
        .unlocked  (unlocked),
        .addr_take (addr_take),
        .data_take (data_take),
        .vol_l     (vol_left),
        .vol_r     (vol_right),
        .rd_val    (ctrl_rd)
    );

    fm_addr_latch #(.DATA_W(DATA_W), .OFF_W(OFF_W), .NBANK(NBANK)) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .port_off  (port_off),
        .ld        (wr_addr && !addr_take),
        .din       (wr_data),
        .main_addr (main_addr),
        .bank_addr (bank_addr)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_scrub
        assign hit[b] = port_off[3] || (port_off[1] == 1'(b));
        fm_bank_scrub #(.DATA_W(DATA_W), .BANK_ID(b)) i_scrub (
            .reg_idx (bank_addr[b]),
            .val_in  (wr_data),
            .keep    (keep[b]),
            .val_out (clean[b])
        );
    end

    // Lane registers: one cycle from data strobe to bank write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank0_we   <= 1'b0;
            bank0_addr <= '0;
            bank0_data <= '0;
            bank1_we   <= 1'b0;
            bank1_addr <= '0;
            bank1_data <= '0;
        end else if (mode == MODE_DUAL) begin
            bank0_we   <= wr_val && hit[0] && keep[0];
            bank0_addr <= {1'b0, bank_addr[0]};
            bank0_data <= clean[0];
            bank1_we   <= wr_val && hit[1] && keep[1];
            bank1_addr <= {1'b1, bank_addr[1]};
            bank1_data <= clean[1];
        end else begin
            bank0_we   <= wr_val && !data_take;
            bank0_addr <= (mode == MODE_SINGLE) ? {1'b0, main_addr[DATA_W-1:0]} : main_addr;
            bank0_data <= wr_data;
            bank1_we   <= 1'b0;
        end
    end

    // Read mux by personality and offset.
    always_comb begin
        rd_data = '1;
        unique case (mode)
            MODE_SINGLE:
                if (port_off[1:0] == 2'b00) rd_data = stat_a | DATA_W'(STAT_OR_BITS);
            MODE_DUAL:
                if (!port_off[0])
                    rd_data = (port_off[1] ? stat_b : stat_a) | DATA_W'(STAT_OR_BITS);
            default: begin
                if (ctrl_mode && unlocked && port_off == OFF_CADDR)
                    rd_data = '0;
                else if (ctrl_mode && unlocked && port_off == OFF_CDATA)
                    rd_data = ctrl_rd;
                else if (port_off[1:0] == 2'b00)
                    rd_data = stat_a;
            end
        endcase
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, REG_W[0]};

endmodule

// File: rtl/fm_port_router_chk.sv
// Temporal checks on the router ports, attached to every instance by bind.
// Assumes single-cycle write strobes as stated in the brief.
module fm_port_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic [3:0] port_off,
    input logic       wr_en,
    input logic       bank0_we,
    input logic [8:0] bank0_addr,
    input logic       bank1_we,
    input logic [8:0] bank1_addr,
    input logic [7:0] bank1_data,
    input logic [7:0] vol_left,
    input logic [7:0] vol_right
);

    AST_LANE0_FROM_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bank0_we |-> ($past(wr_en) && $past(port_off[0]))); // R1

    AST_SINGLE_BYTE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bank0_we && $past(mode_sel) == 2'd0) |-> !bank0_addr[8]); // R1

    AST_LANE1_DUAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bank1_we |-> ($past(mode_sel) == 2'd1 && bank1_addr[8])); // R3

    AST_NO_MODESW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bank1_we |-> (bank1_addr[7:0] != 8'h05)); // R5

    AST_WAVE_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (bank1_we && bank1_addr[7:0] >= 8'hE0) |-> (bank1_data[7:2] == 6'd0)); // R6

    AST_SIDE_BITS_B1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank1_we && bank1_addr[7:0] >= 8'hC0 && bank1_addr[7:0] <= 8'hC8)
        |-> (bank1_data[7:4] == 4'hA)); // R7

    AST_VOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(vol_left) && $stable(vol_right))); // R9

endmodule

bind fm_port_router fm_port_router_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .port_off   (port_off),
    .wr_en      (wr_en),
    .bank0_we   (bank0_we),
    .bank0_addr (bank0_addr),
    .bank1_we   (bank1_we),
    .bank1_addr (bank1_addr),
    .bank1_data (bank1_data),
    .vol_left   (vol_left),
    .vol_right  (vol_right)
);

// File: tb/test_fm_port_router.sv
// Directed bench: one task per scenario, each checking its own results.
module test_fm_port_router;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [3:0] port_off = 4'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] stat_a = 8'h80;
    logic [7:0] stat_b = 8'h40;
    logic [7:0] rd_data;
    logic       bank0_we, bank1_we;
    logic [8:0] bank0_addr, bank1_addr;
    logic [7:0] bank0_data, bank1_data, vol_left, vol_right;

    int tests = 0;
    int fails = 0;
    logic       s_we0, s_we1;
    logic [8:0] s_a0, s_a1;
    logic [7:0] s_d0, s_d1;

    always #5 clk = ~clk;

    fm_port_router i_fm_port_router (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .port_off(port_off),
        .wr_en(wr_en), .wr_data(wr_data), .stat_a(stat_a), .stat_b(stat_b),
        .rd_data(rd_data), .bank0_we(bank0_we), .bank0_addr(bank0_addr),
        .bank0_data(bank0_data), .bank1_we(bank1_we), .bank1_addr(bank1_addr),
        .bank1_data(bank1_data), .vol_left(vol_left), .vol_right(vol_right)
    );

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // One-cycle write; snapshot the lanes after the capturing edge.
    task automatic wr(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        port_off = off; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        s_we0 = bank0_we; s_a0 = bank0_addr; s_d0 = bank0_data;
        s_we1 = bank1_we; s_a1 = bank1_addr; s_d1 = bank1_data;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] off, input string req, input logic [7:0] exp);
        @(negedge clk);
        port_off = off;
        #1 check(req, rd_data, exp);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_sel = m;
    endtask

    task automatic t_reset;
        check("R12 lane0 idle", bank0_we, 0);
        check("R12 lane1 idle", bank1_we, 0);
        check("R12 vol_left", vol_left, 8'hFF);
        check("R12 vol_right", vol_right, 8'hFF);
        set_mode(2'd3);
        rd(4'd2, "R12 locked addr port read", 8'hFF);
        rd(4'd3, "R12 locked data port read", 8'hFF);
        set_mode(2'd0);
        wr(4'd1, 8'h21);
        check("R12 latched address zero", s_a0, 9'h000);
    endtask

    task automatic t_single;
        set_mode(2'd0);
        wr(4'd0, 8'h5A);
        check("R1 no write on address port", s_we0, 0);
        wr(4'd1, 8'h33);
        check("R1 lane0 we", s_we0, 1);
        check("R1 lane0 addr", s_a0, 9'h05A);
        check("R1 lane0 data", s_d0, 8'h33);
        check("R1 lane1 idle", s_we1, 0);
        @(negedge clk);
        check("R1 single-cycle strobe", bank0_we, 0);
        wr(4'd2, 8'hB7);
        wr(4'd3, 8'h01);
        check("R1 8-bit address", s_a0, 9'h0B7);
        rd(4'd0, "R11 single status", 8'h86);
        rd(4'd4, "R11 single status alias", 8'h86);
        rd(4'd1, "R11 single data port", 8'hFF);
    endtask

    task automatic t_ext;
        set_mode(2'd2);
        wr(4'd2, 8'h05);
        wr(4'd3, 8'h01);
        check("R2 high address", s_a0, 9'h105);
        check("R2 value untouched", s_d0, 8'h01);
        check("R2 lane0 we", s_we0, 1);
        wr(4'd0, 8'hE3);
        wr(4'd1, 8'hFF);
        check("R2 low address", s_a0, 9'h0E3);
        check("R2 wave not clipped", s_d0, 8'hFF);
        rd(4'd0, "R11 extended status", 8'h80);
        rd(4'd2, "R11 extended other", 8'hFF);
    endtask

    task automatic t_dual_select;
        set_mode(2'd1);
        wr(4'd0, 8'h20);
        wr(4'd2, 8'h40);
        wr(4'd1, 8'h11);
        check("R3 bank0 we", s_we0, 1);
        check("R3 bank0 addr", s_a0, 9'h020);
        check("R3 bank0 data", s_d0, 8'h11);
        check("R3 bank1 quiet", s_we1, 0);
        wr(4'd3, 8'h22);
        check("R3 bank1 we", s_we1, 1);
        check("R3 bank1 addr", s_a1, 9'h140);
        check("R3 bank1 data", s_d1, 8'h22);
        check("R3 bank0 quiet", s_we0, 0);
    endtask

    task automatic t_dual_bcast;
        set_mode(2'd1);
        wr(4'd8, 8'hA1);
        wr(4'd9, 8'h7E);
        check("R4 both we0", s_we0, 1);
        check("R4 both we1", s_we1, 1);
        check("R4 addr0", s_a0, 9'h0A1);
        check("R4 addr1", s_a1, 9'h1A1);
        check("R4 data1", s_d1, 8'h7E);
        wr(4'd10, 8'h33);
        wr(4'd11, 8'h44);
        check("R4 bit1 ignored when broadcast", {s_we0, s_we1}, 2'b11);
        check("R4 addr0 second", s_a0, 9'h033);
    endtask

    task automatic t_dual_scrub;
        set_mode(2'd1);
        wr(4'd8, 8'h05);
        wr(4'd9, 8'h01);
        check("R5 mode register dropped", {s_we0, s_we1}, 2'b00);
        wr(4'd8, 8'hE7);
        wr(4'd9, 8'hFF);
        check("R6 clip bank0", s_d0, 8'h03);
        check("R6 clip bank1", s_d1, 8'h03);
        wr(4'd8, 8'hDF);
        wr(4'd9, 8'hFF);
        check("R6 below range", s_d0, 8'hFF);
        wr(4'd8, 8'hC4);
        wr(4'd9, 8'h3F);
        check("R7 side bank0", s_d0, 8'h5F);
        check("R7 side bank1", s_d1, 8'hAF);
        wr(4'd8, 8'hC9);
        wr(4'd9, 8'h3F);
        check("R7 above range", s_d1, 8'h3F);
        rd(4'd0, "R11 dual bank0 status", 8'h86);
        rd(4'd2, "R11 dual bank1 status", 8'h46);
        rd(4'd10, "R11 dual bank1 alias", 8'h46);
        rd(4'd1, "R11 dual data port", 8'hFF);
    endtask

    task automatic t_ctrl;
        set_mode(2'd3);
        wr(4'd2, 8'h09);
        wr(4'd3, 8'h44);
        check("R8 locked data write to bank", s_we0, 1);
        check("R8 locked address latched", s_a0, 9'h109);
        check("R8 locked no volume", vol_left, 8'hFF);
        wr(4'd2, 8'hFF);
        check("R8 unlock no lane write", s_we0, 0);
        rd(4'd2, "R10 unlocked addr port", 8'h00);
        wr(4'd2, 8'h09);
        wr(4'd3, 8'h12);
        check("R9 no lane write", s_we0, 0);
        check("R9 left volume", vol_left, 8'h12);
        rd(4'd3, "R10 left readback", 8'h12);
        wr(4'd2, 8'h0A);
        wr(4'd3, 8'h34);
        check("R9 right volume", vol_right, 8'h34);
        wr(4'd2, 8'h00);
        rd(4'd3, "R10 board read", 8'h70);
        wr(4'd2, 8'h15);
        rd(4'd3, "R10 reloc read", 8'h71);
        wr(4'd2, 8'h33);
        rd(4'd3, "R10 other index", 8'hFF);
        wr(4'd3, 8'h99);
        check("R9 other index left", vol_left, 8'h12);
        check("R9 other index right", vol_right, 8'h34);
        check("R9 other index no lane", s_we0, 0);
        rd(4'd0, "R11 status while unlocked", 8'h80);
        wr(4'd2, 8'hFE);
        rd(4'd2, "R8 relocked addr port", 8'hFF);
        wr(4'd3, 8'h55);
        check("R8 index writes left address", s_a0, 9'h109);
        check("R8 relocked data", s_d0, 8'h55);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_ext();
        t_dual_select();
        t_dual_bcast();
        t_dual_scrub();
        t_ctrl();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule